// File: doc/BRIEF.md
# Reference Assignment Count Updater

This unit performs one store of a reference into a reference-holding slot while keeping the reference counts of the two objects involved consistent. Each object starts with a 16-bit header word that packs a 6-bit reference count together with several flags. The header sits two words below the address that the reference holds. The caller presents four things on a start pulse: the slot address, the value the slot holds now (the old reference), the value to be stored (the new reference), and a marking-phase flag. A value of zero means null.

The unit reads the header of the new object and then the header of the old object. It raises a trap code if a count would overflow, if a count would underflow, or if the unit is disabled. Otherwise it writes both headers back and stores the new reference into the slot as two 16-bit words. When the old object's count falls to zero, the unit asks an external zero-count table to record that object. Memory uses a simple request port. A read holds its request until a valid strobe returns the data. A write completes in the cycle it is issued.

Top module: `refc_assign_unit`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `done_o`, `trap_o`, `mem_req_o` and `zct_req_o` are all low. `start_i` is only sampled while idle.
- R2: If `enable_i` is low at start, `done_o` rises in the next cycle with `trap_o` high and trap code 2. No memory access is made.
- R3: If the new object's count field (header bits 6..1) is 63, the unit finishes with trap code 1 and writes nothing. The new header is read before the old one, so this trap wins over any trap from the old object.
- R4: If the unit is enabled and the old and new references are equal, `done_o` rises in the next cycle with no trap and no memory access.
- R5: A header address is the reference minus 2, computed in 32-bit arithmetic so that a borrow carries into the upper half.
- R6: The new object's header is written back with its count plus one and bit 14 (may-be-on-stack) cleared. All other bits are unchanged.
- R7: The old object's header is written back with its count minus one and bit 14 set equal to `mark_mode_i`. Bits 13..7, bit 15 (unless R9 sets it) and bit 0 are unchanged.
- R8: If the old object's count is zero, the unit finishes with trap code 3 when bit 0 (count-overflowed) is set, and with trap code 5 otherwise. It writes nothing.
- R9: When the old object's decremented count is zero and both bit 0 and bit 15 (in-table) are clear, `zct_req_o` pulses once with the old header address before any write. The header is then stored with bit 15 set. Otherwise no request is made and bit 15 is kept.
- R10: Writes are issued in this order: old header, new header, slot low word (slot address, reference bits 15..0), slot high word (slot address + 1, bits 31..16). `done_o` follows the last write.
- R11: A null reference on either side causes no header read and no header write for that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global enable, sampled at start |
| mark_mode_i | input | 1 | Marking-phase flag written into the old header's bit 14 |
| start_i | input | 1 | Start pulse, accepted while idle |
| slot_addr_i | input | 32 | Word address of the slot's low word |
| old_ref_i | input | 32 | Value the slot holds now (0 = null) |
| new_ref_i | input | 32 | Value to store (0 = null) |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Valid with `done_o`: the operation trapped |
| trap_code_o | output | 3 | Trap code (1, 2, 3 or 5), 0 when no trap |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rvalid_i | input | 1 | Read data valid; completes a pending read |
| mem_rdata_i | input | 16 | Read data |
| zct_req_o | output | 1 | Append the old object to the zero-count table |
| zct_addr_o | output | 32 | Header address of the object to append |

## Verification
The hardest case to reach is the append path. It needs a header whose count is exactly one, with the overflowed bit and the in-table bit both clear, and the unit must see that only after the new object's increment has passed without a trap. The bench therefore sweeps the old header over every count value and every combination of the overflowed bit, the in-table bit and the marking flag. It also crosses selected new-side counts with selected old-side counts, which covers the precedence between the two trap sources. Read latency rotates between zero and two cycles, so that the hold-until-valid behaviour of each read is exercised as well.

// File: rtl/refc_pkg.sv
package refc_pkg;

  localparam int HDR_W     = 16;
  localparam int ADDR_W    = 2 * HDR_W;
  localparam int TRAP_W    = 3;
  localparam int BIT_INTAB = 15;
  localparam int BIT_STACK = 14;
  localparam int CNT_LSB   = 1;
  localparam int CNT_W     = 6;
  localparam int BIT_OVF   = 0;

  localparam logic [TRAP_W-1:0] TRAP_NONE  = 3'd0;
  localparam logic [TRAP_W-1:0] TRAP_OVF   = 3'd1;
  localparam logic [TRAP_W-1:0] TRAP_OFF   = 3'd2;
  localparam logic [TRAP_W-1:0] TRAP_UNDER = 3'd3;
  localparam logic [TRAP_W-1:0] TRAP_BUG   = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_NEW, S_RD_OLD, S_ZCT,
    S_WR_OLD, S_WR_NEW, S_WR_LO, S_WR_HI, S_DONE
  } refc_state_e;

  function automatic logic [CNT_W-1:0] cnt_of(input logic [HDR_W-1:0] h);
    return h[CNT_LSB +: CNT_W];
  endfunction

  function automatic logic [HDR_W-1:0] put_cnt(input logic [HDR_W-1:0] h,
                                               input logic [CNT_W-1:0] c);
    logic [HDR_W-1:0] r;
    r = h;
    r[CNT_LSB +: CNT_W] = c;
    return r;
  endfunction

endpackage

// File: rtl/refc_hdr_addr.sv
module refc_hdr_addr #(
  parameter int ADDR_W  = 32,
  parameter int HDR_OFS = 2
) (
  input  logic [ADDR_W-1:0] ref_i,
  output logic [ADDR_W-1:0] hdr_o
);
  // full-width subtraction: a borrow from the low half reaches the high half
  assign hdr_o = ref_i - ADDR_W'(HDR_OFS);
endmodule

// File: rtl/refc_hdr_inc.sv
module refc_hdr_inc
  import refc_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  output logic [HDR_W-1:0] hdr_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt_next = cnt_of(hdr_i) + CNT_W'(1);
    wrap_o   = (cnt_next == '0);
    hdr_o    = put_cnt(hdr_i, cnt_next);
    hdr_o[BIT_STACK] = 1'b0;
  end
endmodule

// File: rtl/refc_hdr_dec.sv
module refc_hdr_dec
  import refc_pkg::*;
(
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic              mark_i,
  output logic [HDR_W-1:0]  hdr_o,
  output logic              under_o,
  output logic [TRAP_W-1:0] code_o,
  output logic              append_o
);
  logic [CNT_W-1:0] cnt_now;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt_now  = cnt_of(hdr_i);
    cnt_next = cnt_now - CNT_W'(1);
    under_o  = (cnt_now == '0);
    code_o   = hdr_i[BIT_OVF] ? TRAP_UNDER : TRAP_BUG;
    append_o = !under_o && (cnt_next == '0) && !hdr_i[BIT_OVF] && !hdr_i[BIT_INTAB];
    hdr_o    = put_cnt(hdr_i, cnt_next);
    hdr_o[BIT_STACK] = mark_i;
    if (append_o) hdr_o[BIT_INTAB] = 1'b1;
  end
endmodule

// File: rtl/refc_ctrl.sv
module refc_ctrl
  import refc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] slot_i,
  input  logic [ADDR_W-1:0] old_ref_i,
  input  logic [ADDR_W-1:0] new_ref_i,
  input  logic [ADDR_W-1:0] old_hdr_addr_i,
  input  logic [ADDR_W-1:0] new_hdr_addr_i,
  input  logic [HDR_W-1:0]  inc_hdr_i,
  input  logic              inc_wrap_i,
  input  logic [HDR_W-1:0]  dec_hdr_i,
  input  logic              dec_under_i,
  input  logic [TRAP_W-1:0] dec_code_i,
  input  logic              dec_append_i,
  input  logic              mem_rvalid_i,
  output logic [ADDR_W-1:0] old_ref_o,
  output logic [ADDR_W-1:0] new_ref_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [TRAP_W-1:0] trap_code_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [HDR_W-1:0]  mem_wdata_o,
  output logic              zct_req_o,
  output logic [ADDR_W-1:0] zct_addr_o
);
  refc_state_e       st;
  logic [ADDR_W-1:0] slot_q, old_q, new_q;
  logic              old_null_q, new_null_q;
  logic [HDR_W-1:0]  old_hdr_q, new_hdr_q;
  logic [TRAP_W-1:0] trap_q;
  logic              wrote_q, app_q;
  logic              ev_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      slot_q     <= '0;
      old_q      <= '0;
      new_q      <= '0;
      old_null_q <= 1'b1;
      new_null_q <= 1'b1;
      old_hdr_q  <= '0;
      new_hdr_q  <= '0;
      trap_q     <= TRAP_NONE;
      wrote_q    <= 1'b0;
      app_q      <= 1'b0;
    end else begin
      if (ev_write) wrote_q <= 1'b1;
      case (st)
        S_IDLE: if (start_i) begin
          slot_q     <= slot_i;
          old_q      <= old_ref_i;
          new_q      <= new_ref_i;
          old_null_q <= (old_ref_i == '0);
          new_null_q <= (new_ref_i == '0);
          trap_q     <= TRAP_NONE;
          wrote_q    <= 1'b0;
          app_q      <= 1'b0;
          if (!enable_i) begin
            trap_q <= TRAP_OFF;
            st     <= S_DONE;
          end else if (old_ref_i == new_ref_i) begin
            st <= S_DONE;
          end else if (new_ref_i != '0) begin
            st <= S_RD_NEW;
          end else begin
            st <= S_RD_OLD;
          end
        end
        S_RD_NEW: if (mem_rvalid_i) begin
          new_hdr_q <= inc_hdr_i;
          if (inc_wrap_i) begin
            trap_q <= TRAP_OVF;
            st     <= S_DONE;
          end else begin
            st <= old_null_q ? S_WR_NEW : S_RD_OLD;
          end
        end
        S_RD_OLD: if (mem_rvalid_i) begin
          old_hdr_q <= dec_hdr_i;
          app_q     <= dec_append_i;
          if (dec_under_i) begin
            trap_q <= dec_code_i;
            st     <= S_DONE;
          end else begin
            st <= dec_append_i ? S_ZCT : S_WR_OLD;
          end
        end
        S_ZCT:    st <= S_WR_OLD;
        S_WR_OLD: st <= new_null_q ? S_WR_LO : S_WR_NEW;
        S_WR_NEW: st <= S_WR_LO;
        S_WR_LO:  st <= S_WR_HI;
        S_WR_HI:  st <= S_DONE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (st)
      S_RD_NEW: begin mem_req_o = 1'b1; mem_addr_o = new_hdr_addr_i; end
      S_RD_OLD: begin mem_req_o = 1'b1; mem_addr_o = old_hdr_addr_i; end
      S_WR_OLD: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = old_hdr_addr_i; mem_wdata_o = old_hdr_q;
      end
      S_WR_NEW: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = new_hdr_addr_i; mem_wdata_o = new_hdr_q;
      end
      S_WR_LO: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = slot_q; mem_wdata_o = new_q[HDR_W-1:0];
      end
      S_WR_HI: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = slot_q + ADDR_W'(1); mem_wdata_o = new_q[ADDR_W-1:HDR_W];
      end
      default: ;
    endcase
  end

  assign ev_write    = mem_req_o && mem_we_o;
  assign old_ref_o   = old_q;
  assign new_ref_o   = new_q;
  assign busy_o      = (st != S_IDLE);
  assign done_o      = (st == S_DONE);
  assign trap_code_o = done_o ? trap_q : TRAP_NONE;
  assign trap_o      = done_o && (trap_q != TRAP_NONE);
  assign zct_req_o   = (st == S_ZCT);
  assign zct_addr_o  = zct_req_o ? old_hdr_addr_i : '0;

  // R2: a disabled request ends next cycle with code 2
  p_off_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i && !enable_i) |=> (done_o && trap_code_o == TRAP_OFF));

  // R4: self-assignment finishes at once without trapping
  p_self_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i && enable_i && old_ref_i == new_ref_i) |=> (done_o && !trap_o && !mem_req_o));

  // R3/R8: a trapped operation has issued no write
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !wrote_q);

  // R9: the append request precedes the old header write
  p_zct_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR_OLD && app_q) |-> $past(zct_req_o));

  // R9: append and memory requests never overlap
  p_req_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(zct_req_o && mem_req_o));

  // R6: the new object's header never leaves with bit 14 set
  p_new_stack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_write && st == S_WR_NEW) |-> !mem_wdata_o[BIT_STACK]);
endmodule

// File: rtl/refc_assign_unit.sv
module refc_assign_unit
  import refc_pkg::*;
#(
  parameter int HDR_OFS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              mark_mode_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] slot_addr_i,
  input  logic [ADDR_W-1:0] old_ref_i,
  input  logic [ADDR_W-1:0] new_ref_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [TRAP_W-1:0] trap_code_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [HDR_W-1:0]  mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [HDR_W-1:0]  mem_rdata_i,
  output logic              zct_req_o,
  output logic [ADDR_W-1:0] zct_addr_o
);
  localparam int NSIDE = 2;  // index 0 = old object, 1 = new object

  logic [ADDR_W-1:0] side_ref  [NSIDE];
  logic [ADDR_W-1:0] side_hdr  [NSIDE];
  logic [HDR_W-1:0]  inc_hdr, dec_hdr;
  logic              inc_wrap, dec_under, dec_append;
  logic [TRAP_W-1:0] dec_code;

  for (genvar g = 0; g < NSIDE; g++) begin : g_addr
    refc_hdr_addr #(.ADDR_W(ADDR_W), .HDR_OFS(HDR_OFS)) u_addr (
      .ref_i (side_ref[g]),
      .hdr_o (side_hdr[g])
    );
  end

  refc_hdr_inc u_inc (
    .hdr_i  (mem_rdata_i),
    .hdr_o  (inc_hdr),
    .wrap_o (inc_wrap)
  );

  refc_hdr_dec u_dec (
    .hdr_i    (mem_rdata_i),
    .mark_i   (mark_mode_i),
    .hdr_o    (dec_hdr),
    .under_o  (dec_under),
    .code_o   (dec_code),
    .append_o (dec_append)
  );

  refc_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .start_i        (start_i),
    .slot_i         (slot_addr_i),
    .old_ref_i      (old_ref_i),
    .new_ref_i      (new_ref_i),
    .old_hdr_addr_i (side_hdr[0]),
    .new_hdr_addr_i (side_hdr[1]),
    .inc_hdr_i      (inc_hdr),
    .inc_wrap_i     (inc_wrap),
    .dec_hdr_i      (dec_hdr),
    .dec_under_i    (dec_under),
    .dec_code_i     (dec_code),
    .dec_append_i   (dec_append),
    .mem_rvalid_i   (mem_rvalid_i),
    .old_ref_o      (side_ref[0]),
    .new_ref_o      (side_ref[1]),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .trap_o         (trap_o),
    .trap_code_o    (trap_code_o),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .zct_req_o      (zct_req_o),
    .zct_addr_o     (zct_addr_o)
  );
endmodule

// File: tb/refc_assign_unit_tb_top.sv
`timescale 1ns/1ps
module refc_assign_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, mark = 1'b0, start = 1'b0;
  logic [31:0] slot = '0, oldr = '0, newr = '0;
  logic        busy, done, trap;
  logic [2:0]  tcode;
  logic        mreq, mwe;
  logic [31:0] maddr;
  logic [15:0] mwdata;
  logic        mrvalid = 1'b0;
  logic [15:0] mrdata = '0;
  logic        zreq;
  logic [31:0] zaddr;

  always #10 clk = ~clk;

  refc_assign_unit dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .mark_mode_i(mark),
    .start_i(start), .slot_addr_i(slot), .old_ref_i(oldr), .new_ref_i(newr),
    .busy_o(busy), .done_o(done), .trap_o(trap), .trap_code_o(tcode),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rvalid_i(mrvalid), .mem_rdata_i(mrdata),
    .zct_req_o(zreq), .zct_addr_o(zaddr)
  );

  int checks = 0, failures = 0;
  logic [15:0] mem [logic [31:0]];
  logic [31:0] act_a [8];
  logic [15:0] act_d [8];
  int act_n = 0, rd_n = 0, zct_n = 0, zct_pos = -1, cur_lat = 0, lat_cnt = 0;
  logic [31:0] zct_seen = '0;

  task automatic chk(input bit ok, input string tg, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
    end
  endtask

  // memory model and observer, all at the falling edge
  always @(negedge clk) begin
    mrvalid = 1'b0;
    if (rst_n) begin
      if (mreq && mwe) begin
        if (act_n < 8) begin act_a[act_n] = maddr; act_d[act_n] = mwdata; end
        act_n++;
        mem[maddr] = mwdata;
      end
      if (zreq) begin zct_n++; zct_seen = zaddr; zct_pos = act_n; end
      if (mreq && !mwe) begin
        if (lat_cnt >= cur_lat) begin
          mrvalid = 1'b1;
          mrdata  = mem.exists(maddr) ? mem[maddr] : 16'h0000;
          rd_n++;
          lat_cnt = 0;
        end else lat_cnt++;
      end else lat_cnt = 0;
    end
  end

  task automatic run_op(input logic [31:0] s, o, n, input logic en, mk,
                        input int lat, input logic [15:0] ho, hn, input string tg);
    logic [31:0] ea [4];
    logic [15:0] ed [4];
    int en_n, ezct, erd, c, k;
    logic [2:0]  etrap;
    logic [15:0] oh, nh;
    logic [31:0] eza;
    if (n != 0) mem[n - 32'd2] = hn;
    if (o != 0) mem[o - 32'd2] = ho;
    etrap = 0; en_n = 0; ezct = 0; erd = 0; eza = '0; oh = '0; nh = '0;
    if (!en) etrap = 3'd2;
    else if (o != n) begin
      if (n != 0) begin
        erd++;
        c = (int'(hn) >> 1) & 63;
        if (c == 63) etrap = 3'd1;
        nh = (hn & 16'hBF81) | 16'((c + 1) << 1);
      end
      if (etrap == 0 && o != 0) begin
        erd++;
        c = (int'(ho) >> 1) & 63;
        if (c == 0) etrap = ho[0] ? 3'd3 : 3'd5;
        else begin
          oh = (ho & 16'hBF81) | 16'((c - 1) << 1) | (mk ? 16'h4000 : 16'h0);
          if (c == 1 && !ho[0] && !ho[15]) begin
            ezct = 1; eza = o - 32'd2; oh = oh | 16'h8000;
          end
        end
      end
      if (etrap == 0) begin
        if (o != 0) begin ea[en_n] = o - 32'd2; ed[en_n] = oh; en_n++; end
        if (n != 0) begin ea[en_n] = n - 32'd2; ed[en_n] = nh; en_n++; end
        ea[en_n] = s;         ed[en_n] = n[15:0];  en_n++;
        ea[en_n] = s + 32'd1; ed[en_n] = n[31:16]; en_n++;
      end
    end
    @(negedge clk);
    cur_lat = lat; act_n = 0; rd_n = 0; zct_n = 0; zct_pos = -1;
    slot = s; oldr = o; newr = n; enable = en; mark = mk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 60) begin @(negedge clk); k++; end
    chk(done, tg, "done", done, 1);
    chk(trap == (etrap != 0), tg, "trap flag", trap, etrap != 0);
    chk(tcode == etrap, tg, "trap code", tcode, etrap);
    chk(rd_n == erd, {tg, " R11"}, "header reads", rd_n, erd);
    chk(act_n == en_n, {tg, " R10"}, "write count", act_n, en_n);
    for (int i = 0; i < en_n && i < act_n && i < 8; i++) begin
      chk(act_a[i] == ea[i], {tg, " R5"}, "write addr", act_a[i], ea[i]);
      chk(act_d[i] == ed[i], {tg, " R6/R7"}, "write data", act_d[i], ed[i]);
    end
    chk(zct_n == ezct, {tg, " R9"}, "append count", zct_n, ezct);
    if (ezct == 1) begin
      chk(zct_seen == eza, "R9", "append addr", zct_seen, eza);
      chk(zct_pos == 0, "R9", "append before writes", zct_pos, 0);
    end
    @(negedge clk);
    chk(!busy, "R1", "idle after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !trap && !mreq && !zreq, "R1", "reset idle",
        {busy, done, trap, mreq, zreq}, 0);

    // R2 disabled
    run_op(32'h100, 32'h200, 32'h300, 1'b0, 1'b0, 0, 16'h0004, 16'h0004, "R2");
    run_op(32'h100, 32'h0,   32'h300, 1'b0, 1'b1, 1, 16'h0004, 16'h0004, "R2");
    // R4 self-assignment
    run_op(32'h100, 32'h400, 32'h400, 1'b1, 1'b0, 0, 16'h0006, 16'h0006, "R4");
    run_op(32'h100, 32'h0,   32'h0,   1'b1, 1'b1, 0, 16'h0000, 16'h0000, "R4");

    // R3/R6: new side sweep over every count
    for (int c = 0; c < 64; c++) begin
      logic [15:0] h;
      h = 16'(c << 1) | 16'((c & 7) << 8) | ((c & 4) != 0 ? 16'h4000 : 16'h0)
        | ((c & 8) != 0 ? 16'h0080 : 16'h0) | ((c & 16) != 0 ? 16'h8001 : 16'h0);
      run_op(32'h1000, 32'h0, 32'h2000 + 32'(c * 4), 1'b1, c[0], c % 3,
             16'h0, h, "R3 R6");
    end

    // R7/R8/R9: old side sweep over count and flag combinations
    for (int c = 0; c < 64; c++) begin
      for (int f = 0; f < 8; f++) begin
        logic [15:0] h;
        h = 16'(c << 1) | 16'h2A00 | (f[0] ? 16'h0001 : 16'h0)
          | (f[1] ? 16'h8000 : 16'h0) | (f[2] ? 16'h0 : 16'h4000)
          | (c[0] ? 16'h0080 : 16'h0);
        run_op(32'h3000, 32'h4000 + 32'(c * 16 + f * 2), 32'h0, 1'b1, f[2],
               (c + f) % 3, h, 16'h0, "R7 R8 R9");
      end
    end

    // R10: both sides, including trap precedence
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 4; b++) begin
        int ca, cb;
        ca = (a == 0) ? 0 : (a == 1) ? 1 : (a == 2) ? 5 : (a == 3) ? 62 : 63;
        cb = (b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 2 : 63;
        run_op(32'h5000, 32'h6000 + 32'(b * 8), 32'h7000 + 32'(a * 8), 1'b1,
               b[0], (a + b) % 3, 16'(cb << 1) | 16'h4100, 16'(ca << 1) | 16'h4200,
               "R10 R3 R8");
      end
    end

    // R5: borrow into the upper half, slot address carrying
    run_op(32'h0000FFFF, 32'h00030000, 32'h00010000, 1'b1, 1'b1, 2,
           16'h0008, 16'h000A, "R5");
    run_op(32'h00020000, 32'h00050000, 32'h0, 1'b1, 1'b0, 1,
           16'h0002, 16'h0, "R5 R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule